// File: doc/BRIEF.md
# Cascaded LFSR Key-Stream Cipher

This block produces a one-bit stream-cipher key from a chain of three 7-bit linear feedback shift registers and combines that key with a one-bit plaintext stream to form ciphertext. The chain is started by a single-cycle start pulse. The first register begins from a fixed all-ones seed. Each later register takes its seed from a fixed window of bits that its predecessor emits. Only the last register drives the key, so the key depends on the whole seeding chain and not on the first register alone.

While the chain is being seeded, the key output is held at 0 and the ciphertext output is 0. Once the third register is loaded, the ready flag rises and stays high. From then on, every cycle presents a new key bit. On cycles where the data-valid input is high, the ciphertext is the plaintext bit XORed with that key bit. Because XOR is its own inverse, the same block restarted with the same start pulse decrypts: feeding ciphertext in as data gives back the plaintext.

Top module: `kstream_cipher`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start pulse, `ready`, `key_bit` and `cipher_bit` are all 0.
- R2: Each register holds positions 1 to 7. On each advance it shifts position k into position k+1 and loads position 1 with the XOR of positions 7 and 6. Its output is position 7. As a result, once ready is high, key bit n+7 equals key bit n XOR key bit n+1.
- R3: A start pulse loads the first register with seven ones.
- R4: Output bits of a register are numbered from 1, where bit 1 is the output present in the first cycle after that register is loaded. The second register is loaded with first-register bits 8 to 14. Bit 8 goes to position 7 and bit 14 goes to position 1, so the second register's bits 1 to 7 repeat that window in order.
- R5: The third register is loaded with second-register bits 15 to 21, in the same placement as in R4. Key bits 1 to 7 therefore equal second-register bits 15 to 21.
- R6: `ready` rises exactly 35 clock edges after the edge that samples `start` high. Until then, `key_bit` is 0. After that, `ready` stays high until the next start pulse.
- R7: Once ready is high, the key stream repeats with a period of 127 bits.
- R8: When `ready` and `din_valid` are both high, `cipher_bit` equals `din` XOR `key_bit`. Otherwise `cipher_bit` is 0.
- R9: Feeding recorded ciphertext back in as `din` after an identical start reproduces the original plaintext on `cipher_bit`.
- R10: A start pulse during seeding, or while ready is high, drops `ready` on the next cycle and restarts the whole seeding sequence from R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts the seeding chain |
| din | input | 1 | Plaintext (or ciphertext) data bit |
| din_valid | input | 1 | Marks `din` as valid this cycle |
| key_bit | output | 1 | Key bit, 0 until ready |
| cipher_bit | output | 1 | `din` XOR key when valid and ready, else 0 |
| ready | output | 1 | High once the last register is seeded |

## Verification
Only the third register is visible at the ports, so a wrong tap, wrong window bounds, wrong bit placement or an off-by-one in a seed window shows up in the key stream. Such an error either shifts the first seven key bits or, through a different seed, changes the entire 127-bit sequence from the first ready cycle onward. A sequencer counting error shows up directly as `ready` rising earlier or later than 35 edges after start. The bench compares every key bit from the first ready cycle against an independently computed sequence, so any such fault is reported within the first key bits after ready.

// File: rtl/ks_pkg.sv
package ks_pkg;
  // register length and feedback positions (1-based)
  localparam int KS_W      = 7;
  localparam int KS_TAP_HI = 7;
  localparam int KS_TAP_LO = 6;
  localparam int KS_STAGES = 3;
  localparam logic [KS_W-1:0] KS_SEED0 = '1;

  // first output bit (1-based) of the window stage s hands to stage s+1
  function automatic int ks_win_first(input int s, input int w);
    return 1 + w * (s + 1);
  endfunction

  typedef enum logic {KS_IDLE = 1'b0, KS_RUN = 1'b1} ks_mode_e;
endpackage

// File: rtl/kstream_lfsr.sv
module kstream_lfsr #(
  parameter int W      = 7,
  parameter int TAP_HI = 7,
  parameter int TAP_LO = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic         out_bit
);
  logic [W-1:0] r_q, r_d;

  always_comb begin
    r_d = r_q;
    if (load) begin
      r_d = seed;
    end else if (adv) begin
      r_d = {r_q[W-2:0], r_q[TAP_HI-1] ^ r_q[TAP_LO-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
    end else if (load || adv) begin
      r_q <= r_d;
    end
  end

  assign out_bit = r_q[W-1];
endmodule

// File: rtl/kstream_win.sv
module kstream_win #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-2:0] hist
);
  logic [W-2:0] hist_d;

  always_comb begin
    hist_d = {hist[W-3:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (shift) begin
      hist <= hist_d;
    end
  end
endmodule

// File: rtl/kstream_seq.sv
module kstream_seq
  import ks_pkg::*;
#(
  parameter int N     = KS_STAGES,
  parameter int W     = KS_W,
  parameter int STG_W = $clog2(N),
  parameter int CNT_W = $clog2(W * N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [N-1:0]     load_vec,
  output logic [N-1:0]     adv_vec,
  output logic             cap_shift,
  output logic [STG_W-1:0] cap_sel,
  output logic             ready
);
  ks_mode_e         mode_q, mode_d;
  logic [STG_W-1:0] stg_q, stg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d    = mode_q;
    stg_d     = stg_q;
    cnt_d     = cnt_q;
    load_vec  = '0;
    adv_vec   = '0;
    cap_shift = 1'b0;
    if (start) begin
      mode_d      = KS_RUN;
      stg_d       = '0;
      cnt_d       = CNT_W'(1);
      load_vec[0] = 1'b1;
    end else if (mode_q == KS_RUN) begin
      for (int i = 0; i < N; i++) begin
        if (stg_q == STG_W'(i)) begin
          adv_vec[i] = 1'b1;
          if (i < N - 1) begin
            if (cnt_q >= CNT_W'(ks_win_first(i, W)) &&
                cnt_q <  CNT_W'(ks_win_first(i, W) + W - 1)) begin
              cap_shift = 1'b1;
            end
            if (cnt_q == CNT_W'(ks_win_first(i, W) + W - 1)) begin
              load_vec[(i + 1) % N] = 1'b1;
              stg_d = STG_W'((i + 1) % N);
              cnt_d = CNT_W'(1);
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= KS_IDLE;
      stg_q  <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      stg_q  <= stg_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cap_sel = stg_q;
  assign ready   = (mode_q == KS_RUN) && (stg_q == STG_W'(N - 1));
endmodule

// File: rtl/kstream_cipher.sv
module kstream_cipher
  import ks_pkg::*;
#(
  parameter int N      = KS_STAGES,
  parameter int W      = KS_W,
  parameter int TAP_HI = KS_TAP_HI,
  parameter int TAP_LO = KS_TAP_LO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din,
  input  logic din_valid,
  output logic key_bit,
  output logic cipher_bit,
  output logic ready
);
  localparam int STG_W = $clog2(N);
  localparam int CNT_W = $clog2(W * N + 1);

  logic [N-1:0]     load_vec, adv_vec, stage_out;
  logic             cap_shift, cap_in;
  logic [STG_W-1:0] cap_sel;
  logic [W-2:0]     win_hist;

  kstream_seq #(.N(N), .W(W), .STG_W(STG_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_vec(load_vec), .adv_vec(adv_vec),
    .cap_shift(cap_shift), .cap_sel(cap_sel), .ready(ready)
  );

  assign cap_in = stage_out[cap_sel];

  kstream_win #(.W(W)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(cap_shift),
    .bit_in(cap_in), .hist(win_hist)
  );

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic [W-1:0] seed;
    if (g == 0) begin : g_fixed
      assign seed = KS_SEED0;
    end else begin : g_chain
      assign seed = {win_hist, stage_out[g-1]};
    end
    kstream_lfsr #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(load_vec[g]), .seed(seed),
      .adv(adv_vec[g]), .out_bit(stage_out[g])
    );
  end

  assign key_bit    = ready & stage_out[N-1];
  assign cipher_bit = (ready & din_valid) ? (din ^ key_bit) : 1'b0;
endmodule

// File: rtl/kstream_chk.sv
module kstream_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic din,
  input logic din_valid,
  input logic key_bit,
  input logic cipher_bit,
  input logic ready
);
  logic [6:0] hist;
  logic [3:0] nrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      nrun <= '0;
    end else begin
      hist <= {hist[5:0], key_bit};
      if (start || !ready) begin
        nrun <= '0;
      end else if (nrun < 4'd8) begin
        nrun <= nrun + 4'd1;
      end
    end
  end

  // R6
  key_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !key_bit);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

  // R10
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  // R8
  cipher_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && din_valid) |-> ((cipher_bit ^ din) == key_bit));

  // R8
  cipher_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && din_valid) |-> !cipher_bit);

  // R2
  recur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && nrun >= 4'd7) |-> (key_bit == (hist[6] ^ hist[5])));
endmodule

bind kstream_cipher kstream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .din(din), .din_valid(din_valid),
  .key_bit(key_bit), .cipher_bit(cipher_bit), .ready(ready)
);

// File: tb/kstream_cipher_test.sv
module kstream_cipher_test;
  localparam int CLK_NS = 10;
  localparam int NK     = 300;

  logic clk = 1'b0;
  logic rst_n, start, din, din_valid;
  logic key_bit, cipher_bit, ready;

  int n_chk = 0;
  int n_bad = 0;
  logic kexp [NK];
  logic obs  [NK];
  logic ptx  [100];
  logic ctx  [100];

  always #(CLK_NS / 2) clk = ~clk;

  kstream_cipher uut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .din_valid(din_valid),
    .key_bit(key_bit), .cipher_bit(cipher_bit), .ready(ready)
  );

  function automatic logic [6:0] step7(input logic [6:0] r);
    return {r[5:0], r[6] ^ r[5]};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // pulse start and check ready timing, leaves sim at first ready cycle
  task automatic start_and_wait();
    pulse_start();
    chk("R10 ready drops after start", ready, 1'b0);
    for (int m = 1; m <= 35; m++) begin
      @(negedge clk);
      if (m < 35) begin
        chk("R6 not ready while seeding", ready, 1'b0);
        chk("R6 key zero while seeding", key_bit, 1'b0);
      end else begin
        chk("R6 ready after 35 edges", ready, 1'b1);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; din = 1'b1; din_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", ready, 1'b0);
    chk("R1 key in reset", key_bit, 1'b0);
    chk("R1 cipher in reset", cipher_bit, 1'b0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R1 idle ready", ready, 1'b0);
      chk("R1 idle cipher", cipher_bit, 1'b0);
    end
    din_valid = 1'b0; din = 1'b0;
  endtask

  task automatic t_keystream();
    start_and_wait();
    for (int j = 0; j < 260; j++) begin
      obs[j] = key_bit;
      if (j < 7) chk("R5 first key bits = stage-2 bits 15..21", key_bit, kexp[j]);
      else       chk("R3 R4 key sequence", key_bit, kexp[j]);
      chk("R6 ready stays high", ready, 1'b1);
      @(negedge clk);
    end
    for (int j = 7; j < 260; j++) chk("R2 recurrence", obs[j], obs[j-7] ^ obs[j-6]);
    for (int j = 0; j < 133; j++) chk("R7 period 127", obs[j+127], obs[j]);
  endtask

  task automatic t_cipher();
    start_and_wait();
    for (int j = 0; j < 60; j++) begin
      din       = logic'(((j * 5) + (j / 3)) % 2);
      din_valid = (j % 4) != 3;
      #1;
      chk("R8 cipher", cipher_bit, din_valid ? (din ^ kexp[j]) : 1'b0);
      @(negedge clk);
    end
    din_valid = 1'b0; din = 1'b0;
  endtask

  task automatic t_decrypt();
    start_and_wait();
    for (int j = 0; j < 100; j++) begin
      ptx[j] = logic'(((j * 7) / 3) % 2);
      din = ptx[j]; din_valid = 1'b1;
      #1;
      ctx[j] = cipher_bit;
      @(negedge clk);
    end
    din_valid = 1'b0;
    start_and_wait();
    for (int j = 0; j < 100; j++) begin
      din = ctx[j]; din_valid = 1'b1;
      #1;
      chk("R9 decrypt recovers plaintext", cipher_bit, ptx[j]);
      @(negedge clk);
    end
    din_valid = 1'b0; din = 1'b0;
  endtask

  task automatic t_restart();
    pulse_start();
    repeat (20) @(negedge clk);
    start_and_wait();
    for (int j = 0; j < 20; j++) begin
      chk("R10 restart mid-seeding key", key_bit, kexp[j]);
      @(negedge clk);
    end
    start_and_wait();
    for (int j = 0; j < 20; j++) begin
      chk("R10 restart while ready key", key_bit, kexp[j]);
      @(negedge clk);
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run clears ready", ready, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [6:0] r;
    logic s1 [1:14];
    logic s2 [1:21];
    logic [6:0] seed2, seed3;
    r = 7'h7F;
    for (int k = 1; k <= 14; k++) begin s1[k] = r[6]; r = step7(r); end
    for (int k = 8; k <= 14; k++) seed2[14 - k] = s1[k];
    r = seed2;
    for (int k = 1; k <= 21; k++) begin s2[k] = r[6]; r = step7(r); end
    for (int k = 15; k <= 21; k++) seed3[21 - k] = s2[k];
    r = seed3;
    for (int j = 0; j < NK; j++) begin kexp[j] = r[6]; r = step7(r); end

    t_reset();
    t_keystream();
    t_cipher();
    t_decrypt();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule